// File: doc/BRIEF.md
# GPIO Port With Strobe Override

A small general-purpose I/O port. Each pin has an output latch bit and a direction bit. The two lowest pins also have a function bit. When a pin's function bit is set, the pin stops acting as a port output and carries a CPU bus strobe instead: pin 0 carries the active-low read strobe and pin 1 carries the active-low write strobe. In strobe mode the pin's latch bit acts as a gate. With latch 0 the strobe reaches the pin on every bus access. With latch 1 it reaches the pin only while the external address area is being accessed; the rest of the time the pin is held high (inactive).

The CPU writes the latch, direction and function registers through a simple select/data write port and reads the pin states back. A two-bit boot mode, applied while reset is asserted, selects the reset function of pins 0 and 1. Two of its codes are reserved; if one of them is seen, both pins come up as plain outputs.

Top module: `gpio_strobe_port`

## Requirements
- R1: While reset is asserted and after its release, every output latch bit is 1.
- R2: After reset, pins 2 and 3 are inputs (`pad_oe_o` bit 0) with pull-up enabled, and pins 0 and 1 are outputs.
- R3: Boot mode decode at reset, function bits {pin1,pin0}: code 2'b01 gives 2'b01 (read strobe only), code 2'b10 gives 2'b11 (both strobes), codes 2'b00 and 2'b11 are reserved and give 2'b00 (plain outputs).
- R4: A write with `wr_en_i`=1 updates the register chosen by `wr_sel_i` on the next rising clock edge: 0 = output latch, 1 = direction (1 = output), 2 = function (data bits 1:0 go to pins 1:0). Select 3 changes no register.
- R5: A pin whose function bit is 0 drives its latch bit on `pad_o`; `pad_oe_o` is 1 when its direction bit is 1 or its function bit is 1.
- R6: With pin 0 in strobe mode and latch bit 0 equal to 0, `pad_o[0]` follows `rd_n_i` whatever `ext_i` is.
- R7: With pin 0 in strobe mode and latch bit 0 equal to 1, `pad_o[0]` follows `rd_n_i` when `ext_i` is 1 and is 1 when `ext_i` is 0.
- R8: Pin 1 in strobe mode follows `wr_n_i` under the same gating rule as R6 and R7, using latch bit 1.
- R9: `rd_data_o` returns the latch bit for every pin whose output enable is 1 and the live `pad_i` bit for every other pin.
- R10: `pullup_o` is 1 exactly for pins whose output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boot_mode_i | input | 2 | Boot mode, decoded while reset is asserted |
| wr_en_i | input | 1 | Register write enable |
| wr_sel_i | input | 2 | Register select: 0 latch, 1 direction, 2 function |
| wr_data_i | input | WIDTH | Write data |
| rd_data_o | output | WIDTH | Pin read-back |
| rd_n_i | input | 1 | Internal read strobe, active low |
| wr_n_i | input | 1 | Internal write strobe, active low |
| ext_i | input | 1 | High while the external address area is accessed |
| pad_i | input | WIDTH | Live pad input values |
| pad_o | output | WIDTH | Pad output values |
| pad_oe_o | output | WIDTH | Pad output enables |
| pullup_o | output | WIDTH | Pad pull-up enables |

## Verification
The assertions expect at most one register write per cycle and take the boot mode to be stable from reset assertion through release, so that the reset function bits are well defined. They also treat the strobe and area inputs as settled by the sampling clock edge. The stimulus only changes inputs on the falling clock edge, holds the boot mode constant across each reset pulse, and issues single-cycle writes. It sweeps every boot code, every latch and function combination against every strobe and area combination, and every direction pattern for read-back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NSTB = 2;

  typedef enum logic [1:0] {
    SEL_LATCH = 2'd0,
    SEL_DIR   = 2'd1,
    SEL_FUNC  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  // reset function bits {pin1, pin0}; reserved codes fall back to plain outputs
  function automatic logic [NSTB-1:0] boot_func(input logic [1:0] mode);
    case (mode)
      2'b01:   boot_func = 2'b01;
      2'b10:   boot_func = 2'b11;
      default: boot_func = 2'b00;
    endcase
  endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       boot_mode_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [NSTB-1:0]  func_o
);
  localparam logic [WIDTH-1:0] DirRst = {{(WIDTH-NSTB){1'b0}}, {NSTB{1'b1}}};

  reg_sel_e sel;
  assign sel = reg_sel_e'(wr_sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_o <= '1;
      dir_o   <= DirRst;
      func_o  <= boot_func(boot_mode_i);
    end else if (wr_en_i) begin
      case (sel)
        SEL_LATCH: latch_o <= wr_data_i;
        SEL_DIR:   dir_o   <= wr_data_i;
        SEL_FUNC:  func_o  <= wr_data_i[NSTB-1:0];
        default:   ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_strobe_gate.sv
module gpio_strobe_gate (
  input  logic strobe_n_i,
  input  logic latch_i,
  input  logic ext_i,
  output logic gated_n_o
);
  // latch 0: pass on every access; latch 1: pass on external area only
  always_comb begin
    if (!latch_i || ext_i) gated_n_o = strobe_n_i;
    else                   gated_n_o = 1'b1;
  end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
  import gpio_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] latch_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [NSTB-1:0]  func_i,
  input  logic [NSTB-1:0]  strobe_n_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pullup_o,
  output logic [WIDTH-1:0] rd_data_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i < NSTB) begin : g_stb
      assign pad_o[i]    = func_i[i] ? strobe_n_i[i] : latch_i[i];
      assign pad_oe_o[i] = dir_i[i] | func_i[i];
    end else begin : g_plain
      assign pad_o[i]    = latch_i[i];
      assign pad_oe_o[i] = dir_i[i];
    end
    assign pullup_o[i]  = ~pad_oe_o[i];
    assign rd_data_o[i] = pad_oe_o[i] ? latch_i[i] : pad_i[i];
  end
endmodule

// File: rtl/gpio_strobe_port.sv
module gpio_strobe_port
  import gpio_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       boot_mode_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] rd_data_o,
  input  logic             rd_n_i,
  input  logic             wr_n_i,
  input  logic             ext_i,
  input  logic [WIDTH-1:0] pad_i,
  output logic [WIDTH-1:0] pad_o,
  output logic [WIDTH-1:0] pad_oe_o,
  output logic [WIDTH-1:0] pullup_o
);
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [NSTB-1:0]  func_q;
  logic [NSTB-1:0]  strobe_raw_n;
  logic [NSTB-1:0]  strobe_gated_n;

  assign strobe_raw_n = {wr_n_i, rd_n_i};

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_mode_i (boot_mode_i),
    .wr_en_i     (wr_en_i),
    .wr_sel_i    (wr_sel_i),
    .wr_data_i   (wr_data_i),
    .latch_o     (latch_q),
    .dir_o       (dir_q),
    .func_o      (func_q)
  );

  for (genvar s = 0; s < NSTB; s++) begin : g_gate
    gpio_strobe_gate u_gate (
      .strobe_n_i (strobe_raw_n[s]),
      .latch_i    (latch_q[s]),
      .ext_i      (ext_i),
      .gated_n_o  (strobe_gated_n[s])
    );
  end

  gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
    .latch_i    (latch_q),
    .dir_i      (dir_q),
    .func_i     (func_q),
    .strobe_n_i (strobe_gated_n),
    .pad_i      (pad_i),
    .pad_o      (pad_o),
    .pad_oe_o   (pad_oe_o),
    .pullup_o   (pullup_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/gpio_strobe_port_chk.sv
module gpio_strobe_port_chk
  import gpio_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic             rd_n_i,
  input logic             wr_n_i,
  input logic             ext_i,
  input logic [WIDTH-1:0] pad_o,
  input logic [WIDTH-1:0] pad_oe_o,
  input logic [WIDTH-1:0] pullup_o,
  input logic [WIDTH-1:0] latch_q,
  input logic [WIDTH-1:0] dir_q,
  input logic [NSTB-1:0]  func_q
);
  AST_LATCH_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd0) |=> latch_q == $past(wr_data_i)); // R4
  AST_SEL3_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'd3) |=> ($stable(latch_q) && $stable(dir_q) && $stable(func_q))); // R4
  AST_RD_STROBE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_q[0] && !latch_q[0]) |-> pad_o[0] == rd_n_i); // R6
  AST_RD_STROBE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_q[0] && latch_q[0] && !ext_i) |-> pad_o[0]); // R7
  AST_WR_STROBE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (func_q[1] && (!latch_q[1] || ext_i)) |-> pad_o[1] == wr_n_i); // R8
  AST_PULL_ONLY_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pullup_o) == '0); // R10
  AST_STROBE_PIN_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    func_q[0] |-> pad_oe_o[0]); // R5
endmodule

bind gpio_strobe_port gpio_strobe_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .rd_n_i    (rd_n_i),
  .wr_n_i    (wr_n_i),
  .ext_i     (ext_i),
  .pad_o     (pad_o),
  .pad_oe_o  (pad_oe_o),
  .pullup_o  (pullup_o),
  .latch_q   (latch_q),
  .dir_q     (dir_q),
  .func_q    (func_q)
);

// File: tb/gpio_strobe_port_bench.sv
`timescale 1ns/1ps
module gpio_strobe_port_bench;
  localparam int W = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [1:0]   boot_mode_i = 2'b00;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_sel_i = 2'd0;
  logic [W-1:0] wr_data_i = '0;
  logic [W-1:0] rd_data_o;
  logic         rd_n_i = 1'b1;
  logic         wr_n_i = 1'b1;
  logic         ext_i = 1'b0;
  logic [W-1:0] pad_i = '0;
  logic [W-1:0] pad_o;
  logic [W-1:0] pad_oe_o;
  logic [W-1:0] pullup_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_strobe_port #(.WIDTH(W)) u_gpio_strobe_port (.*);

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%b exp=%b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset(input logic [1:0] mode);
    @(negedge clk_i);
    boot_mode_i = mode;
    rst_ni = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] data);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
  endtask

  function automatic logic gate(input logic s_n, input logic l, input logic e);
    return (!l || e) ? s_n : 1'b1;
  endfunction

  initial begin
    logic [1:0] efunc;
    logic [W-1:0] exp_o;
    // reset state for each boot code
    for (int m = 0; m < 4; m++) begin
      pad_i = 4'b0000;
      do_reset(2'(m));
      efunc = (m == 1) ? 2'b01 : (m == 2) ? 2'b11 : 2'b00;
      check("R2 oe after reset", pad_oe_o, 4'b0011);
      check("R2/R10 pullup after reset", pullup_o, 4'b1100);
      check("R1 latch readback after reset", rd_data_o, 4'b0011);
      for (int c = 0; c < 8; c++) begin
        ext_i = c[0]; rd_n_i = c[1]; wr_n_i = c[2];
        #1;
        exp_o[0] = efunc[0] ? gate(rd_n_i, 1'b1, ext_i) : 1'b1;
        exp_o[1] = efunc[1] ? gate(wr_n_i, 1'b1, ext_i) : 1'b1;
        exp_o[3:2] = 2'b11;
        check("R3 boot function via pad_o", pad_o, exp_o);
      end
      pad_i = 4'b1100;
      #1;
      check("R1 latch high on inputs via readback", rd_data_o, 4'b1111);
    end

    // strobe gating sweep
    do_reset(2'b00);
    wr(2'd1, 4'b1111);
    for (int f = 0; f < 4; f++) begin
      wr(2'd2, 4'(f));
      for (int l = 0; l < 16; l++) begin
        wr(2'd0, 4'(l));
        for (int c = 0; c < 8; c++) begin
          ext_i = c[0]; rd_n_i = c[1]; wr_n_i = c[2];
          #1;
          exp_o = 4'(l);
          if (f[0]) exp_o[0] = gate(rd_n_i, l[0], ext_i); // R6 R7
          if (f[1]) exp_o[1] = gate(wr_n_i, l[1], ext_i); // R8
          check("R5/R6/R7/R8 pad_o", pad_o, exp_o);
        end
      end
    end

    // direction / readback sweep with function bits cleared
    wr(2'd2, 4'b0000);
    for (int l = 0; l < 16; l += 5) begin
      wr(2'd0, 4'(l));
      for (int d = 0; d < 16; d++) begin
        wr(2'd1, 4'(d));
        for (int p = 0; p < 16; p += 3) begin
          pad_i = 4'(p);
          #1;
          check("R5 oe", pad_oe_o, 4'(d));
          check("R10 pullup", pullup_o, ~4'(d));
          check("R9 readback", rd_data_o, (4'(d) & 4'(l)) | (~4'(d) & 4'(p)));
        end
      end
    end

    // function bit forces oe even with direction input
    wr(2'd1, 4'b0000);
    wr(2'd2, 4'b0011);
    pad_i = 4'b0000;
    wr(2'd0, 4'b1111);
    #1;
    check("R5 strobe pin oe with dir 0", pad_oe_o, 4'b0011);
    check("R9 readback of strobe pins", rd_data_o, 4'b0011);

    // select 3 ignored
    wr(2'd3, 4'b0000);
    ext_i = 1'b0; rd_n_i = 1'b0; wr_n_i = 1'b0;
    #1;
    check("R4 sel3 keeps latch (gate stays closed)", pad_o, 4'b1111);
    check("R4 sel3 keeps dir/func", pad_oe_o, 4'b0011);
    check("R4 sel3 keeps readback", rd_data_o, 4'b0011);

    // write takes effect on next edge only
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_sel_i = 2'd0; wr_data_i = 4'b0000;
    #1;
    check("R4 no change before edge", pad_o, 4'b1111);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #1;
    check("R4 latch after edge", pad_o, 4'b0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule